// File: doc/BRIEF.md
# Interleaved Bank Request Buffer

This block accepts vector load/store requests from several request sources and spreads them across an interleaved memory whose bank count is prime-like (2^k+1, seventeen by default). Each request carries a word address and a tag. On capture, the address is split into a bank index (address modulo the bank count) and an in-bank row (address divided by the bank count). With this mapping, strides that are powers of two visit every bank before they revisit one. Captured requests wait in a small buffer that always keeps its entries in arrival order. Every cycle, each idle bank takes the oldest waiting request addressed to it. As a result, a younger request to a free bank overtakes older requests that are stuck behind a busy bank.

Each bank is a two-state controller. In `BK_IDLE` it can be granted a request. The transition *grant* moves it to `BK_BUSY`, produces a one-cycle issue pulse and loads an occupancy countdown. In `BK_BUSY` the countdown runs. The transition *expiry* returns the bank to `BK_IDLE` and produces a one-cycle completion pulse that carries the tag. The buffer holds back further requests through a ready signal when it cannot take a full set of source requests.

Top module: `bank_req_buffer`

## Requirements
- R1: A request with address A is issued on the port of bank A mod NBANK, with row A div NBANK and its own tag.
- R2: A request captured at a clock edge, whose bank is idle and has no older waiting request, shows its issue pulse in the cycle that follows the next edge (two cycles after it was presented).
- R3: An issue pulse lasts one cycle, and two issues to the same bank are at least BUSY_CYC cycles apart. While that bank has a backlog, they are exactly BUSY_CYC cycles apart.
- R4: A completion pulse appears on the bank's completion port BUSY_CYC-1 cycles after its issue pulse and carries the issued tag. From the following cycle the bank can issue again.
- R5: Requests to one bank are issued in arrival order. Among requests presented in the same cycle, the lower source index counts as older.
- R6: A request to an idle bank is issued even while older requests to busy banks are still waiting.
- R7: The ready output is high exactly when the buffer held at most DEPTH-NSRC entries after the last edge. Requests presented while ready is low are ignored. Every accepted request is issued exactly once.
- R8: After reset, no issue or completion pulse is present, the buffer is empty and ready is high.
- R9: NBANK consecutive elements at any power-of-two stride map to NBANK distinct banks and are issued without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NSRC | Per-source request present |
| req_addr | input | NSRC x ADDR_W | Per-source word address |
| req_tag | input | NSRC x TAG_W | Per-source request tag |
| req_ready | output | 1 | Buffer can take a request from every source this cycle |
| iss_valid | output | NBANK | Per-bank one-cycle issue pulse |
| iss_row | output | NBANK x (ADDR_W-clog2(NBANK)+1) | Row within the bank for the issued request |
| iss_tag | output | NBANK x TAG_W | Tag of the issued request |
| cmpl_valid | output | NBANK | Per-bank completion pulse |
| cmpl_tag | output | NBANK x TAG_W | Tag of the completed access |

## Verification
The hardest condition to reach from the ports is a full buffer. Getting there requires a backlog on a single bank that grows faster than the one-per-BUSY_CYC drain. The stimulus sends a dozen requests to one bank, two per cycle, which holds ready low for several cycles. While ready is low, it presents an extra request whose tag must never come out. Each cycle's logged ready value is compared with an occupancy computed from the acceptance and issue cycles of every tag. Bypass and same-cycle ordering are tested by mixing three requests to one bank with one request to a free bank across two cycles, and by checking the exact issue cycle of each.

// File: rtl/bank_req_pkg.sv
package bank_req_pkg;

    // Per-bank controller states
    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_BUSY = 1'b1
    } bank_state_e;

endpackage

// File: rtl/bank_map.sv
// Splits a word address into bank index and in-bank row.
module bank_map #(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 17,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);

    localparam logic [ADDR_W-1:0] DIVISOR = ADDR_W'(NBANK);

    always_comb begin
        bank = BANK_W'(addr % DIVISOR);
        row  = ROW_W'(addr / DIVISOR);
    end

endmodule

// File: rtl/req_queue.sv
// Age-ordered request buffer: slot 0 is always the oldest entry.
// Each idle bank takes its oldest waiting entry; survivors are compacted
// towards slot 0 and newly accepted requests are appended behind them.
module req_queue #(
    parameter int NSRC   = 2,
    parameter int NBANK  = 17,
    parameter int DEPTH  = 8,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 12,
    parameter int TAG_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NSRC-1:0]                   in_acc,
    input  logic [NSRC-1:0][BANK_W-1:0]       in_bank,
    input  logic [NSRC-1:0][ROW_W-1:0]        in_row,
    input  logic [NSRC-1:0][TAG_W-1:0]        in_tag,
    input  logic [NBANK-1:0]                  bank_idle,
    output logic [NBANK-1:0]                  gnt,
    output logic [NBANK-1:0][ROW_W-1:0]       gnt_row,
    output logic [NBANK-1:0][TAG_W-1:0]       gnt_tag,
    output logic [CNT_W-1:0]                  occ
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DEPTH-1:0]              q_vld,  n_vld;
    logic [DEPTH-1:0][BANK_W-1:0]  q_bank, n_bank;
    logic [DEPTH-1:0][ROW_W-1:0]   q_row,  n_row;
    logic [DEPTH-1:0][TAG_W-1:0]   q_tag,  n_tag;
    logic [DEPTH-1:0]              take;
    logic [CNT_W-1:0]              n_occ;

    // Selection: scan from oldest; first entry per idle bank wins.
    always_comb begin
        logic [NBANK-1:0] claim;
        claim   = '0;
        take    = '0;
        gnt_row = '0;
        gnt_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_vld[i] && bank_idle[q_bank[i]] && !claim[q_bank[i]]) begin
                take[i]             = 1'b1;
                claim[q_bank[i]]    = 1'b1;
                gnt_row[q_bank[i]]  = q_row[i];
                gnt_tag[q_bank[i]]  = q_tag[i];
            end
        end
        gnt = claim;
    end

    // Compaction and append.
    always_comb begin
        logic [CNT_W-1:0] n;
        n      = '0;
        n_vld  = '0;
        n_bank = '0;
        n_row  = '0;
        n_tag  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_vld[i] && !take[i]) begin
                n_vld[n[IDX_W-1:0]]  = 1'b1;
                n_bank[n[IDX_W-1:0]] = q_bank[i];
                n_row[n[IDX_W-1:0]]  = q_row[i];
                n_tag[n[IDX_W-1:0]]  = q_tag[i];
                n = n + CNT_W'(1);
            end
        end
        for (int s = 0; s < NSRC; s++) begin
            if (in_acc[s] && (n < FULL)) begin
                n_vld[n[IDX_W-1:0]]  = 1'b1;
                n_bank[n[IDX_W-1:0]] = in_bank[s];
                n_row[n[IDX_W-1:0]]  = in_row[s];
                n_tag[n[IDX_W-1:0]]  = in_tag[s];
                n = n + CNT_W'(1);
            end
        end
        n_occ = n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= '0;
            q_bank <= '0;
            q_row  <= '0;
            q_tag  <= '0;
            occ    <= '0;
        end else begin
            q_vld  <= n_vld;
            q_bank <= n_bank;
            q_row  <= n_row;
            q_tag  <= n_tag;
            occ    <= n_occ;
        end
    end

endmodule

// File: rtl/bank_slot.sv
// One memory bank: idle/busy controller with an occupancy countdown.
module bank_slot
    import bank_req_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int TAG_W    = 8,
    parameter int BUSY_CYC = 6,
    parameter int CYC_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic [ROW_W-1:0]  grant_row,
    input  logic [TAG_W-1:0]  grant_tag,
    output logic              idle,
    output logic              iss_valid,
    output logic [ROW_W-1:0]  iss_row,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              cmpl_valid,
    output logic [TAG_W-1:0]  cmpl_tag
);

    localparam logic [CYC_W-1:0] LOAD = CYC_W'(BUSY_CYC - 1);
    localparam logic [CYC_W-1:0] LAST = CYC_W'(1);

    bank_state_e      state, state_nxt;
    logic [CYC_W-1:0] remain;
    logic             do_grant, do_expire;

    always_comb begin
        state_nxt = state;
        unique case (state)
            BK_IDLE: if (grant)          state_nxt = BK_BUSY;
            BK_BUSY: if (remain == LAST) state_nxt = BK_IDLE;
        endcase
    end

    assign do_grant  = (state == BK_IDLE) && grant;
    assign do_expire = (state == BK_BUSY) && (state_nxt == BK_IDLE);
    assign idle      = (state == BK_IDLE);

    // State register and countdown
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BK_IDLE;
            remain <= '0;
        end else begin
            state <= state_nxt;
            unique case (state)
                BK_IDLE: if (grant) remain <= LOAD;
                BK_BUSY: remain <= remain - CYC_W'(1);
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid  <= 1'b0;
            iss_row    <= '0;
            iss_tag    <= '0;
            cmpl_valid <= 1'b0;
            cmpl_tag   <= '0;
        end else begin
            iss_valid  <= do_grant;
            cmpl_valid <= do_expire;
            if (do_grant) begin
                iss_row <= grant_row;
                iss_tag <= grant_tag;
            end
            if (do_expire) begin
                cmpl_tag <= iss_tag;
            end
        end
    end

endmodule

// File: rtl/bank_req_buffer.sv
module bank_req_buffer
    import bank_req_pkg::*;
#(
    parameter int NSRC     = 2,
    parameter int NBANK    = 17,
    parameter int ADDR_W   = 16,
    parameter int TAG_W    = 8,
    parameter int DEPTH    = 8,
    parameter int BUSY_CYC = 6
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic [NSRC-1:0]                                   req_valid,
    input  logic [NSRC-1:0][ADDR_W-1:0]                       req_addr,
    input  logic [NSRC-1:0][TAG_W-1:0]                        req_tag,
    output logic                                              req_ready,
    output logic [NBANK-1:0]                                  iss_valid,
    output logic [NBANK-1:0][ADDR_W-$clog2(NBANK):0]          iss_row,
    output logic [NBANK-1:0][TAG_W-1:0]                       iss_tag,
    output logic [NBANK-1:0]                                  cmpl_valid,
    output logic [NBANK-1:0][TAG_W-1:0]                       cmpl_tag
);

    localparam int BANK_W = $clog2(NBANK);
    localparam int ROW_W  = ADDR_W - BANK_W + 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int CYC_W  = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] ROOM = CNT_W'(DEPTH - NSRC);

    logic [NSRC-1:0][BANK_W-1:0]  map_bank;
    logic [NSRC-1:0][ROW_W-1:0]   map_row;
    logic [NSRC-1:0]              acc;
    logic [NBANK-1:0]             bank_idle;
    logic [NBANK-1:0]             gnt;
    logic [NBANK-1:0][ROW_W-1:0]  gnt_row;
    logic [NBANK-1:0][TAG_W-1:0]  gnt_tag;
    logic [CNT_W-1:0]             buf_occ;

    assign req_ready = (buf_occ <= ROOM);
    assign acc       = req_valid & {NSRC{req_ready}};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        bank_map #(
            .ADDR_W (ADDR_W),
            .NBANK  (NBANK),
            .BANK_W (BANK_W),
            .ROW_W  (ROW_W)
        ) u_map (
            .addr (req_addr[s]),
            .bank (map_bank[s]),
            .row  (map_row[s])
        );
    end

    req_queue #(
        .NSRC   (NSRC),
        .NBANK  (NBANK),
        .DEPTH  (DEPTH),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .in_acc    (acc),
        .in_bank   (map_bank),
        .in_row    (map_row),
        .in_tag    (req_tag),
        .bank_idle (bank_idle),
        .gnt       (gnt),
        .gnt_row   (gnt_row),
        .gnt_tag   (gnt_tag),
        .occ       (buf_occ)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_slot #(
            .ROW_W    (ROW_W),
            .TAG_W    (TAG_W),
            .BUSY_CYC (BUSY_CYC),
            .CYC_W    (CYC_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .grant      (gnt[b]),
            .grant_row  (gnt_row[b]),
            .grant_tag  (gnt_tag[b]),
            .idle       (bank_idle[b]),
            .iss_valid  (iss_valid[b]),
            .iss_row    (iss_row[b]),
            .iss_tag    (iss_tag[b]),
            .cmpl_valid (cmpl_valid[b]),
            .cmpl_tag   (cmpl_tag[b])
        );
    end

endmodule

// File: rtl/bank_req_buffer_chk.sv
module bank_req_buffer_chk #(
    parameter int NSRC     = 2,
    parameter int NBANK    = 17,
    parameter int TAG_W    = 8,
    parameter int DEPTH    = 8,
    parameter int BUSY_CYC = 6,
    parameter int CNT_W    = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         req_ready,
    input logic [NBANK-1:0]             iss_valid,
    input logic [NBANK-1:0][TAG_W-1:0]  iss_tag,
    input logic [NBANK-1:0]             cmpl_valid,
    input logic [NBANK-1:0][TAG_W-1:0]  cmpl_tag,
    input logic [CNT_W-1:0]             occ
);

    localparam int GAP_W = $clog2(BUSY_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(BUSY_CYC);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [GAP_W-1:0] gap;
        logic             seen;
        logic [TAG_W-1:0] last_tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                gap      <= '0;
                seen     <= 1'b0;
                last_tag <= '0;
            end else if (iss_valid[b]) begin
                gap      <= '0;
                seen     <= 1'b1;
                last_tag <= iss_tag[b];
            end else if (gap != GAP_MAX) begin
                gap <= gap + GAP_W'(1);
            end
        end

        // R3: same-bank issues separated by the busy time
        p_spacing_r3: assert property (@(posedge clk) disable iff (rst)
            (iss_valid[b] && seen) |-> (gap >= GAP_W'(BUSY_CYC - 1)));

        // R3: issue is a single-cycle pulse
        p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
            iss_valid[b] |=> !iss_valid[b]);

        // R4: completion follows the issue after the fixed interval
        p_cmpl_gap_r4: assert property (@(posedge clk) disable iff (rst)
            cmpl_valid[b] |-> (seen && (gap == GAP_W'(BUSY_CYC - 2))));

        // R4: completion carries the issued tag
        p_cmpl_tag_r4: assert property (@(posedge clk) disable iff (rst)
            cmpl_valid[b] |-> (cmpl_tag[b] == last_tag));
    end

    // R7: buffer never exceeds its depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    // R7: nothing enters while ready is low
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (occ <= $past(occ)));

endmodule

bind bank_req_buffer bank_req_buffer_chk #(
    .NSRC     (NSRC),
    .NBANK    (NBANK),
    .TAG_W    (TAG_W),
    .DEPTH    (DEPTH),
    .BUSY_CYC (BUSY_CYC),
    .CNT_W    (CNT_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .iss_valid  (iss_valid),
    .iss_tag    (iss_tag),
    .cmpl_valid (cmpl_valid),
    .cmpl_tag   (cmpl_tag),
    .occ        (buf_occ)
);

// File: tb/test_bank_req_buffer.sv
module test_bank_req_buffer;

    localparam int NSRC     = 2;
    localparam int NBANK    = 17;
    localparam int ADDR_W   = 16;
    localparam int TAG_W    = 8;
    localparam int DEPTH    = 8;
    localparam int BUSY_CYC = 6;
    localparam int ROW_W    = ADDR_W - $clog2(NBANK) + 1;

    logic                              clk = 1'b0;
    logic                              rst = 1'b1;
    logic [NSRC-1:0]                   req_valid;
    logic [NSRC-1:0][ADDR_W-1:0]       req_addr;
    logic [NSRC-1:0][TAG_W-1:0]        req_tag;
    logic                              req_ready;
    logic [NBANK-1:0]                  iss_valid;
    logic [NBANK-1:0][ROW_W-1:0]       iss_row;
    logic [NBANK-1:0][TAG_W-1:0]       iss_tag;
    logic [NBANK-1:0]                  cmpl_valid;
    logic [NBANK-1:0][TAG_W-1:0]       cmpl_tag;

    bank_req_buffer #(
        .NSRC(NSRC), .NBANK(NBANK), .ADDR_W(ADDR_W),
        .TAG_W(TAG_W), .DEPTH(DEPTH), .BUSY_CYC(BUSY_CYC)
    ) i_bank_req_buffer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
        .req_ready(req_ready),
        .iss_valid(iss_valid), .iss_row(iss_row), .iss_tag(iss_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk  = 0;
    int nfail = 0;

    int iss_cnt  [0:255];
    int iss_cyc  [0:255];
    int iss_bank [0:255];
    int iss_rowv [0:255];
    int cmpl_cnt [0:255];
    int cmpl_cyc [0:255];
    int cmpl_bank[0:255];
    int drv_cyc  [0:255];
    bit ready_log[0:4095];

    // Output logger, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int t;
            if (cyc < 4096) ready_log[cyc] = req_ready;
            for (int b = 0; b < NBANK; b++) begin
                if (iss_valid[b]) begin
                    t = int'(iss_tag[b]);
                    iss_cnt[t]  = iss_cnt[t] + 1;
                    iss_cyc[t]  = cyc;
                    iss_bank[t] = b;
                    iss_rowv[t] = int'(iss_row[b]);
                end
                if (cmpl_valid[b]) begin
                    t = int'(cmpl_tag[b]);
                    cmpl_cnt[t]  = cmpl_cnt[t] + 1;
                    cmpl_cyc[t]  = cyc;
                    cmpl_bank[t] = b;
                end
            end
        end
    end

    task automatic chk(input string msg, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic clear_logs();
        for (int t = 0; t < 256; t++) begin
            iss_cnt[t] = 0;  iss_cyc[t] = -1; iss_bank[t] = -1; iss_rowv[t] = -1;
            cmpl_cnt[t] = 0; cmpl_cyc[t] = -1; cmpl_bank[t] = -1; drv_cyc[t] = -1;
        end
    endtask

    // Present up to two requests in one cycle, waiting for ready first
    task automatic send2(input bit v0, input int a0, input int t0,
                         input bit v1, input int a1, input int t1);
        while (!req_ready) @(negedge clk);
        req_valid   = {v1, v0};
        req_addr[0] = ADDR_W'(a0);
        req_tag[0]  = TAG_W'(t0);
        req_addr[1] = ADDR_W'(a1);
        req_tag[1]  = TAG_W'(t1);
        if (v0) drv_cyc[t0] = cyc;
        if (v1) drv_cyc[t1] = cyc;
        @(negedge clk);
    endtask

    task automatic idle_n(input int n);
        req_valid = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_stride(input int stride);
        int mask;
        clear_logs();
        for (int e = 0; e < NBANK; e += 2)
            send2(1'b1, 3 + e * stride, e, (e + 1 < NBANK), 3 + (e + 1) * stride, e + 1);
        idle_n(20);
        mask = 0;
        for (int e = 0; e < NBANK; e++) begin
            int a;
            a = 3 + e * stride;
            chk($sformatf("R1 bank stride %0d elem %0d", stride, e), iss_bank[e], a % NBANK);
            chk($sformatf("R1 row stride %0d elem %0d", stride, e), iss_rowv[e], a / NBANK);
            chk($sformatf("R7 issued once stride %0d elem %0d", stride, e), iss_cnt[e], 1);
            chk($sformatf("R2 latency stride %0d elem %0d", stride, e), iss_cyc[e], drv_cyc[e] + 2);
            chk($sformatf("R4 completion time stride %0d elem %0d", stride, e),
                cmpl_cyc[e], iss_cyc[e] + BUSY_CYC - 1);
            chk($sformatf("R4 completion bank stride %0d elem %0d", stride, e), cmpl_bank[e], iss_bank[e]);
            if (iss_bank[e] >= 0) mask = mask | (1 << iss_bank[e]);
        end
        chk($sformatf("R9 distinct banks stride %0d", stride), $countones(mask), NBANK);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        int d0;
        req_valid = '0;
        req_addr  = '0;
        req_tag   = '0;
        clear_logs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        chk("R8 no issue after reset", int'(iss_valid), 0);
        chk("R8 no completion after reset", int'(cmpl_valid), 0);
        chk("R8 ready after reset", int'(req_ready), 1);

        // R1, R2, R4, R9: power-of-two stride sweeps
        for (int k = 0; k < 7; k++) run_stride(1 << k);

        // R5, R6: conflicts, ordering and bypass
        clear_logs();
        send2(1'b1, 0, 1, 1'b1, 17, 2);
        send2(1'b1, 34, 3, 1'b1, 5, 4);
        idle_n(25);
        d0 = drv_cyc[1];
        chk("R5 source 0 first", iss_cyc[1], d0 + 2);
        chk("R5 same-cycle source 1 next", iss_cyc[2], d0 + 2 + BUSY_CYC);
        chk("R5 later request last", iss_cyc[3], d0 + 2 + 2 * BUSY_CYC);
        chk("R6 bypass of waiting requests", iss_cyc[4], d0 + 3);
        chk("R1 row of second same-bank request", iss_rowv[2], 1);
        chk("R1 row of third same-bank request", iss_rowv[3], 2);
        chk("R1 bypass bank", iss_bank[4], 5);
        for (int t = 1; t <= 4; t++)
            chk($sformatf("R4 completion tag %0d", t), cmpl_cyc[t], iss_cyc[t] + BUSY_CYC - 1);

        // R3, R5, R7: back-pressure on one bank
        clear_logs();
        for (int i = 0; i < 8; i += 2)
            send2(1'b1, 3 + 17 * i, 10 + i, 1'b1, 3 + 17 * (i + 1), 11 + i);
        chk("R7 ready low when buffer full", int'(req_ready), 0);
        req_valid   = 2'b01;
        req_addr[0] = ADDR_W'(3);
        req_tag[0]  = TAG_W'(99);
        @(negedge clk);
        for (int i = 8; i < 12; i += 2)
            send2(1'b1, 3 + 17 * i, 10 + i, 1'b1, 3 + 17 * (i + 1), 11 + i);
        idle_n(BUSY_CYC * 14);
        chk("R7 request ignored while not ready", iss_cnt[99], 0);
        chk("R2 first backlog latency", iss_cyc[10], drv_cyc[10] + 2);
        for (int i = 0; i < 12; i++) begin
            chk($sformatf("R7 backlog issued once %0d", i), iss_cnt[10 + i], 1);
            chk($sformatf("R3 R5 backlog spacing %0d", i), iss_cyc[10 + i], iss_cyc[10] + BUSY_CYC * i);
            chk($sformatf("R1 backlog row %0d", i), iss_rowv[10 + i], i);
            chk($sformatf("R4 backlog completion %0d", i), cmpl_cyc[10 + i], iss_cyc[10 + i] + BUSY_CYC - 1);
        end
        for (int k = drv_cyc[10] + 1; k <= iss_cyc[21] && k < 4096; k++) begin
            int occ;
            occ = 0;
            for (int t = 10; t < 22; t++)
                if (drv_cyc[t] >= 0 && drv_cyc[t] + 1 <= k && k < iss_cyc[t]) occ++;
            chk($sformatf("R7 ready at cycle %0d occupancy %0d", k, occ),
                int'(ready_log[k]), int'(occ <= DEPTH - NSRC));
        end

        summary();
        $finish;
    end

endmodule